// File: doc/BRIEF.md
# Debounced edge event counter

This block is the front end of one input-capture channel. A selector picks one of four external lines or an internal test signal. The chosen line is resynchronised to the block clock and then cleaned by a debounce filter whose length is programmable. The cleaned level drives an edge detector. Depending on the edge mode, the detector qualifies rising edges, falling edges or both.

Every qualifying edge is reported as a one-cycle pulse for the capture path and is counted. When the count reaches a programmed threshold, a sticky interrupt is raised and the count starts again from zero. Software drops the interrupt with a clear strobe or by disabling the channel. A disabled channel holds the filter, the edge detector and the counter in their reset state.

All pins are plain level control and status signals. The edge pulse is a single-cycle strobe with no back-pressure: the capture path must accept it in the cycle it appears.

Top module: `edge_event_counter`

## Requirements
- R1: `src_sel` values 0 to 3 pick `ext_in[0]` to `ext_in[3]`, value 4 picks `test_sig`, and values 5 to 7 force the selected line to 0, so no edges are produced.
- R2: With `filt_code` 0 to 6, the filtered level follows a new input level only after `filt_code`+1 consecutive samples at that level. A level change on the input held at the negative clock edge before cycle c shows as an `edge_pulse` in cycle c+3+`filt_code`. A shorter glitch produces no edge.
- R3: With `filt_code` 7, the filtered level needs 16 consecutive samples, so a 15-cycle excursion produces no edge and a held change gives `edge_pulse` in cycle c+18.
- R4: `edge_mode` 0 qualifies rising edges of the filtered level, 1 qualifies falling edges, and 2 qualifies both. Code 3 is reserved.
- R5: `edge_pulse` is high for exactly one cycle per qualifying edge and never for a non-qualifying edge.
- R6: With `threshold` N (0 to 15), `irq` rises one cycle after the `edge_pulse` of the (N+1)th qualifying edge. Example: N=7 fires on the 8th edge.
- R7: `irq` stays high until `irq_clr` is pulsed; it is low one cycle after the strobe, unless a threshold hit lands in that same cycle. When `irq` is raised, the event count restarts from zero.
- R8: With `enable` low, `irq` is low one cycle later and no edges are reported. On re-enable, the filtered level starts at 0, so a line already high gives one rising edge.
- R9: During reset `irq` and `edge_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Channel enable; low holds the channel in reset |
| src_sel | input | 3 | Input line selector |
| ext_in | input | 4 | External input lines |
| test_sig | input | 1 | Internal test signal |
| filt_code | input | 3 | Debounce length code |
| edge_mode | input | 2 | Edge qualification mode |
| threshold | input | 4 | Edge count threshold N, fires after N+1 |
| irq_clr | input | 1 | Interrupt clear strobe |
| irq | output | 1 | Sticky interrupt |
| edge_pulse | output | 1 | One-cycle qualified edge strobe |

## Verification
The bench builds the block with its default parameters: four external lines, a 3-bit filter code with a long length of 16, and a 4-bit threshold. With these values the 16-sample filter case and the threshold of 7 both fit in short windows, so exact pulse timing at codes 0, 2 and 7 is checked cycle by cycle. The bench also covers one-sample-short glitches, threshold restart after an interrupt, every selector code class, and the rising edge produced by enabling a channel whose line is already high.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    EM_RISE  = 2'd0,
    EM_FALL  = 2'd1,
    EM_BOTH  = 2'd2,
    EM_RSVD  = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/evc_src_mux.sv
module evc_src_mux #(
  parameter int N_EXT = 4,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [N_EXT-1:0] ext,
  input  logic             tst,
  output logic             line
);
  always_comb begin
    line = 1'b0;
    for (int i = 0; i < N_EXT; i++) begin
      if (sel == SEL_W'(i)) line = ext[i];
    end
    if (sel == SEL_W'(N_EXT)) line = tst;
  end
endmodule

// File: rtl/evc_sync.sv
module evc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/evc_debounce.sv
module evc_debounce #(
  parameter int CODE_W   = 3,
  parameter int LONG_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              din,
  input  logic [CODE_W-1:0] code,
  output logic              level
);
  localparam int CW = $clog2(LONG_LEN + 1);

  logic [CW-1:0] run_cnt;
  logic [CW-1:0] need;

  // Nonlinear length: all-ones selects the long filter.
  always_comb begin
    if (code == {CODE_W{1'b1}}) need = CW'(LONG_LEN);
    else                        need = CW'(code) + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= 1'b0;
      run_cnt <= '0;
    end else if (hold) begin
      level   <= 1'b0;
      run_cnt <= '0;
    end else if (din == level) begin
      run_cnt <= '0;
    end else if (run_cnt + CW'(1) == need) begin
      level   <= din;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + CW'(1);
    end
  end
endmodule

// File: rtl/evc_edge_count.sv
module evc_edge_count
  import evc_pkg::*;
#(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             level,
  input  edge_mode_e       mode,
  input  logic [THR_W-1:0] thr,
  input  logic             clr,
  output logic             pulse,
  output logic             irq
);
  logic             prev;
  logic [THR_W-1:0] ev_cnt;
  logic             rise, fall, hit;

  assign rise = level & ~prev;
  assign fall = ~level & prev;

  always_comb begin
    unique case (mode)
      EM_RISE: pulse = rise;
      EM_FALL: pulse = fall;
      default: pulse = rise | fall;
    endcase
  end

  assign hit = pulse && (ev_cnt == thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev   <= 1'b0;
      ev_cnt <= '0;
      irq    <= 1'b0;
    end else if (hold) begin
      prev   <= 1'b0;
      ev_cnt <= '0;
      irq    <= 1'b0;
    end else begin
      prev <= level;
      if (hit)        ev_cnt <= '0;
      else if (pulse) ev_cnt <= ev_cnt + THR_W'(1);
      if (hit)        irq <= 1'b1;
      else if (clr)   irq <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_event_counter.sv
module edge_event_counter
  import evc_pkg::*;
#(
  parameter int N_EXT       = 4,
  parameter int SEL_W       = 3,
  parameter int CODE_W      = 3,
  parameter int LONG_LEN    = 16,
  parameter int THR_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [SEL_W-1:0]  src_sel,
  input  logic [N_EXT-1:0]  ext_in,
  input  logic              test_sig,
  input  logic [CODE_W-1:0] filt_code,
  input  logic [1:0]        edge_mode,
  input  logic [THR_W-1:0]  threshold,
  input  logic              irq_clr,
  output logic              irq,
  output logic              edge_pulse
);
  logic sel_line, synced, filtered, hold;

  assign hold = ~enable;

  evc_src_mux #(.N_EXT(N_EXT), .SEL_W(SEL_W)) u_mux (
    .sel(src_sel), .ext(ext_in), .tst(test_sig), .line(sel_line)
  );

  evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sel_line), .dout(synced)
  );

  evc_debounce #(.CODE_W(CODE_W), .LONG_LEN(LONG_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .hold(hold), .din(synced),
    .code(filt_code), .level(filtered)
  );

  evc_edge_count #(.THR_W(THR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold(hold), .level(filtered),
    .mode(edge_mode_e'(edge_mode)), .thr(threshold), .clr(irq_clr),
    .pulse(edge_pulse), .irq(irq)
  );
endmodule

// File: rtl/evc_chk.sv
module evc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [1:0] edge_mode,
  input logic       irq_clr,
  input logic       irq,
  input logic       edge_pulse
);
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr && enable) |=> irq);

  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !edge_pulse) |=> !irq);

  // R8
  disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !irq);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && $past(!enable)) |-> !edge_pulse);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(edge_pulse));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_pulse && !edge_mode[1]) |=> !(edge_pulse && $stable(edge_mode)));
endmodule

bind edge_event_counter evc_chk u_evc_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .edge_mode(edge_mode),
  .irq_clr(irq_clr), .irq(irq), .edge_pulse(edge_pulse)
);

// File: tb/test_edge_event_counter.sv
module test_edge_event_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [2:0] src_sel;
  logic [3:0] ext_in;
  logic       test_sig;
  logic [2:0] filt_code;
  logic [1:0] edge_mode;
  logic [3:0] threshold;
  logic       irq_clr;
  logic       irq;
  logic       edge_pulse;

  edge_event_counter i_edge_event_counter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
    .ext_in(ext_in), .test_sig(test_sig), .filt_code(filt_code),
    .edge_mode(edge_mode), .threshold(threshold), .irq_clr(irq_clr),
    .irq(irq), .edge_pulse(edge_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    cyc;
    int    pulse;   // 0, 1, or 2 = not checked
    int    irqv;    // 0, 1, or 2 = not checked
    string tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int npulse = 0;
  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check_eq(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Monitor: counts strobes and retires scoreboard items in their cycle.
  always @(negedge clk) begin
    item_t it;
    if (rst_n && edge_pulse) npulse++;
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      it = sbq.pop_front();
      check_eq({it.tag, " item cycle"}, cyc, it.cyc);
      if (it.pulse != 2) check_eq({it.tag, " edge_pulse"}, int'(edge_pulse), it.pulse);
      if (it.irqv != 2)  check_eq({it.tag, " irq"}, int'(irq), it.irqv);
    end
  end

  // Driver helpers
  task automatic expect_at(int dc, int p, int q, string tag);
    item_t it;
    it.cyc = cyc + dc; it.pulse = p; it.irqv = q; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_line(int ln, logic v);
    if (ln < 4) ext_in[ln] = v;
    else        test_sig = v;
  endtask

  task automatic pulses(int ln, int n);
    for (int i = 0; i < n; i++) begin
      set_line(ln, 1'b1); waitn(4);
      set_line(ln, 1'b0); waitn(4);
    end
    waitn(2);
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1; waitn(1); irq_clr = 1'b0; waitn(1);
  endtask

  task automatic restart();
    ext_in = '0; test_sig = 1'b0;
    enable = 1'b0; waitn(3);
    enable = 1'b1; waitn(4);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int np;
    rst_n = 1'b0; enable = 1'b0; src_sel = 3'd0; ext_in = '0; test_sig = 1'b0;
    filt_code = 3'd0; edge_mode = 2'd0; threshold = 4'd0; irq_clr = 1'b0;
    waitn(3);
    check_eq("R9 reset irq", int'(irq), 0);
    check_eq("R9 reset edge_pulse", int'(edge_pulse), 0);
    rst_n = 1'b1; waitn(1);
    enable = 1'b1; waitn(4);

    // Code 0, rising, threshold 0: exact timing
    ext_in[0] = 1'b1;
    expect_at(3, 1, 0, "R2 code0 edge");
    expect_at(4, 0, 1, "R6 thr0 irq");
    waitn(8);
    check_eq("R7 irq sticky", int'(irq), 1);
    irq_clr = 1'b1;
    expect_at(1, 2, 0, "R7 clear");
    waitn(1); irq_clr = 1'b0; waitn(1);
    np = npulse;
    ext_in[0] = 1'b0; waitn(8);
    check_eq("R4 falling ignored in rise mode", npulse - np, 0);
    check_eq("R4 no irq on falling", int'(irq), 0);

    // Code 2: glitch rejected, held level timed
    filt_code = 3'd2; np = npulse;
    ext_in[0] = 1'b1; waitn(2); ext_in[0] = 1'b0; waitn(10);
    check_eq("R2 short glitch rejected", npulse - np, 0);
    ext_in[0] = 1'b1;
    expect_at(4, 0, 2, "R2 code2 not early");
    expect_at(5, 1, 2, "R2 code2 edge");
    waitn(8);
    clear_irq();

    // Code 7, both edges
    filt_code = 3'd7; edge_mode = 2'd2; np = npulse;
    ext_in[0] = 1'b0; waitn(15); ext_in[0] = 1'b1; waitn(20);
    check_eq("R3 15-cycle dip rejected", npulse - np, 0);
    ext_in[0] = 1'b0;
    expect_at(17, 0, 2, "R3 code7 not early");
    expect_at(18, 1, 2, "R3 code7 edge");
    waitn(22);
    clear_irq();

    // Falling mode, threshold 2
    filt_code = 3'd0; edge_mode = 2'd1; threshold = 4'd2;
    restart(); np = npulse;
    pulses(0, 2);
    check_eq("R5 one strobe per falling edge", npulse - np, 2);
    check_eq("R6 no irq before N+1", int'(irq), 0);
    pulses(0, 1);
    check_eq("R6 irq on third falling edge", int'(irq), 1);

    // Both edges, threshold 3
    edge_mode = 2'd2; threshold = 4'd3;
    restart(); np = npulse;
    pulses(0, 1); ext_in[0] = 1'b1; waitn(6);
    check_eq("R4 both mode edge count", npulse - np, 3);
    check_eq("R4 no irq after 3 edges", int'(irq), 0);
    ext_in[0] = 1'b0; waitn(6);
    check_eq("R4 irq after 4 edges", int'(irq), 1);

    // Threshold 7 and restart after interrupt
    edge_mode = 2'd0; threshold = 4'd7;
    restart();
    pulses(0, 7);
    check_eq("R6 thr7 quiet after 7", int'(irq), 0);
    pulses(0, 1);
    check_eq("R6 thr7 fires on 8th", int'(irq), 1);
    clear_irq();
    pulses(0, 7);
    check_eq("R7 count restarted", int'(irq), 0);
    pulses(0, 1);
    check_eq("R7 fires again on 8th", int'(irq), 1);

    // Source selection
    threshold = 4'd0;
    restart();
    src_sel = 3'd5; np = npulse;
    ext_in = 4'hF; test_sig = 1'b1; waitn(8);
    ext_in = 4'h0; test_sig = 1'b0; waitn(8);
    check_eq("R1 code5 forces zero", npulse - np, 0);
    check_eq("R1 code5 no irq", int'(irq), 0);
    src_sel = 3'd4; np = npulse;
    pulses(4, 1);
    check_eq("R1 test signal selected", npulse - np, 1);
    check_eq("R1 test signal irq", int'(irq), 1);
    clear_irq();
    src_sel = 3'd3; np = npulse;
    pulses(0, 1); pulses(1, 1); pulses(2, 1);
    check_eq("R1 unselected lines ignored", npulse - np, 0);
    pulses(3, 1);
    check_eq("R1 line 3 selected", npulse - np, 1);

    // Disable behaviour
    check_eq("R8 irq set before disable", int'(irq), 1);
    enable = 1'b0;
    expect_at(1, 0, 0, "R8 disable drops irq");
    waitn(3); np = npulse;
    pulses(3, 1);
    check_eq("R8 no edges while disabled", npulse - np, 0);
    check_eq("R8 irq low while disabled", int'(irq), 0);
    ext_in[3] = 1'b1; waitn(4);
    enable = 1'b1; waitn(8);
    check_eq("R8 high line on enable gives edge", npulse - np, 1);
    check_eq("R8 enable edge counted", int'(irq), 1);
    ext_in[3] = 1'b0; waitn(6);
    check_eq("scoreboard drained", sbq.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule